// File: doc/BRIEF.md
# Display Timing Register Port with Unlock Key

This block is the byte-wide, indexed register file that a display timing controller exposes to a host over a small I/O bus. The host writes a register number to an index port and then reads or writes that register through the data port next to it. A miscellaneous output register chooses which of two address pairs the index/data ports answer on. The file holds twenty-five standard timing bytes, whose first eight can be write-protected, and a bank of sixteen extended bytes. The extended bank stays hidden until the host writes a two-byte key.

A mode-switch bit lets software say that a timing change is in progress. When that bit is cleared, a busy flag rises and stays up until the next vertical-blank pulse, so software can tell when the new timing has taken effect. Two read-only signature bytes identify the register interface. The 10-bit line pitch, in units of 8 bytes, is assembled from one standard byte and two bits of one extended byte, and is driven out for the timing engine.

Writes take effect on the rising clock edge while `io_wr` is high. Reads are combinational: `io_rdata` shows the addressed value while `io_rd` is high and is 0x00 otherwise.

Top module: `crtc_regport`

## Requirements
- R1: The miscellaneous output register is written at I/O address 0x3C2 and read back, all 8 bits, at 0x3CC.
- R2: When bit 0 of the miscellaneous register is 1, the index port is at 0x3D4 and the data port at 0x3D5. Otherwise they are at 0x3B4 and 0x3B5. Writes to the inactive pair have no effect, reads there return 0x00, and a read of the index port returns the current index.
- R3: A data write to index 0x30 drives the key state machine. Writing 0x57 arms it. Writing 0x4C while it is armed opens the extended bank. Any other value, including 0x00, or 0x4C without a preceding 0x57, leaves the bank locked. Index 0x30 reads 0x00.
- R4: Extended indices 0x40 to 0x4F hold 16 writable bytes while the bank is open. While it is locked, writes to them are ignored and reads return 0x00; the stored contents survive and reappear on the next unlock.
- R5: Standard indices 0x00 to 0x18 are readable and writable. While bit 7 of index 0x11 is 1, writes to indices 0x00 to 0x07 are ignored. Writing 0x00 to index 0x11 lifts the protection. Index 0x11 and the indices above 0x07 stay writable at all times.
- R6: Output `line_pitch` is {bits 1:0 of extended index 0x45, standard index 0x13}, a 10-bit count of 8-byte units.
- R7: Bit 0 of index 0x3F is the mode-switch bit. It can be written only while the bank is open, and it reads back in bit 0 with bits 7:1 reading 0.
- R8: Clearing the mode-switch bit from 1 to 0 sets a busy flag, which reads as bit 7 of index 0x33 (bits 6:0 read 0). The flag clears at the first clock edge where `vblank` is high. If the clearing write and `vblank` fall on the same edge, the flag is set.
- R9: Index 0x35 reads 0x43 (ASCII 'C') and index 0x36 reads 0x58 (ASCII 'X'), whether or not the bank is open.
- R10: Indices with no register behind them read 0x00, and writes to them have no effect.
- R11: Reset clears all register state, the index, the key state and the busy flag to 0. After reset the ports are therefore at 0x3B4/0x3B5 and the bank is locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0x00 when `io_rd` is low |
| vblank | input | 1 | Vertical-blank pulse |
| line_pitch | output | 10 | Line pitch in 8-byte units |

## Verification
The bench builds the block with its default parameters: 25 standard registers, 16 extended registers based at 0x40, and protection covering indices 0x00 to 0x07. With these values every address decode, the protection edge at index 0x07 against 0x12, and the pitch split across indices 0x13 and 0x45 can be reached directly. Directed sequences cover:
- both port pairs,
- a broken key order and the correct one,
- contents kept across a lock and relock,
- a busy flag cleared by a vertical-blank pulse, and one set on the same edge as that pulse.

// File: rtl/crtc_regport.sv
module crtc_regport #(
  parameter int STD_NUM  = 25,
  parameter int EXT_NUM  = 16,
  parameter int EXT_BASE = 'h40,
  parameter int PROT_TOP = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        vblank,
  output logic [9:0]  line_pitch
);
  localparam logic [15:0] MISC_WA  = 16'h03C2;
  localparam logic [15:0] MISC_RA  = 16'h03CC;
  localparam logic [7:0]  KEY_IDX  = 8'h30;
  localparam logic [7:0]  BUSY_IDX = 8'h33;
  localparam logic [7:0]  SIG0_IDX = 8'h35;
  localparam logic [7:0]  SIG1_IDX = 8'h36;
  localparam logic [7:0]  MODE_IDX = 8'h3F;
  localparam int PROT_IDX = 'h11;
  localparam int PLO_IDX  = 'h13;
  localparam int PHI_OFF  = 5;
  localparam logic [1:0] ST_SHUT = 2'd0, ST_ARMED = 2'd1, ST_OPEN = 2'd2;

  logic [7:0] misc_q, idx_q;
  logic [STD_NUM-1:0][7:0] std_q;
  logic [EXT_NUM-1:0][7:0] ext_q;
  logic [1:0] ulk_st;
  logic mode_q, busy_q;
  logic [7:0] rd_val;

  wire [15:0] idx_port = misc_q[0] ? 16'h03D4 : 16'h03B4;
  wire [15:0] dat_port = idx_port + 16'd1;
  wire        unlocked = (ulk_st == ST_OPEN);
  wire        prot     = std_q[PROT_IDX][7];
  wire        dwr      = io_wr && (io_addr == dat_port);
  wire        mode_wr  = dwr && (idx_q == MODE_IDX) && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= '0;
      idx_q  <= '0;
      std_q  <= '0;
      ext_q  <= '0;
      ulk_st <= ST_SHUT;
      mode_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (io_wr && io_addr == MISC_WA) misc_q <= io_wdata;
      if (io_wr && io_addr == idx_port) idx_q <= io_wdata;
      if (dwr) begin
        for (int i = 0; i < STD_NUM; i++)
          if (idx_q == 8'(i) && !(prot && i <= PROT_TOP)) std_q[i] <= io_wdata;
        for (int i = 0; i < EXT_NUM; i++)
          if (unlocked && idx_q == 8'(EXT_BASE + i)) ext_q[i] <= io_wdata;
        if (idx_q == KEY_IDX) begin
          if (io_wdata == 8'h57) ulk_st <= ST_ARMED;
          else if (io_wdata == 8'h4C && ulk_st == ST_ARMED) ulk_st <= ST_OPEN;
          else ulk_st <= ST_SHUT;
        end
      end
      if (mode_wr) mode_q <= io_wdata[0];
      if (mode_wr && mode_q && !io_wdata[0]) busy_q <= 1'b1;
      else if (vblank) busy_q <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (io_addr == MISC_RA) rd_val = misc_q;
    else if (io_addr == idx_port) rd_val = idx_q;
    else if (io_addr == dat_port) begin
      case (idx_q)
        BUSY_IDX: rd_val = {busy_q, 7'b0};
        SIG0_IDX: rd_val = 8'h43;
        SIG1_IDX: rd_val = 8'h58;
        MODE_IDX: rd_val = {7'b0, mode_q};
        default: begin
          for (int i = 0; i < STD_NUM; i++)
            if (idx_q == 8'(i)) rd_val = std_q[i];
          for (int i = 0; i < EXT_NUM; i++)
            if (unlocked && idx_q == 8'(EXT_BASE + i)) rd_val = ext_q[i];
        end
      endcase
    end
  end

  assign io_rdata   = io_rd ? rd_val : 8'h00;
  assign line_pitch = {ext_q[PHI_OFF][1:0], std_q[PLO_IDX]};
endmodule

// File: rtl/crtc_regport_chk.sv
module crtc_regport_chk #(
  parameter int EXT_NUM  = 16,
  parameter int EXT_BASE = 'h40
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic        vblank,
  input logic        color,
  input logic [7:0]  idx_q,
  input logic [1:0]  ulk_st,
  input logic        mode_q,
  input logic        busy_q,
  input logic        prot,
  input logic [EXT_NUM-1:0][7:0] ext_q,
  input logic [7:0][7:0] std_lo
);
  wire [15:0] dat = color ? 16'h03D5 : 16'h03B5;
  wire ext_idx = (idx_q >= 8'(EXT_BASE)) && (idx_q < 8'(EXT_BASE + EXT_NUM));

  assert_key_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulk_st == 2'd2) |-> $past(ulk_st) == 2'd1);

  assert_ext_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ulk_st != 2'd2) |=> $stable(ext_q));

  assert_ext_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == dat && ext_idx && ulk_st != 2'd2) |-> io_rdata == 8'h00);

  assert_prot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> $stable(std_lo));

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> busy_q);

  assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !mode_q) |=> !busy_q);

  assert_signature_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == dat && idx_q == 8'h35) |-> io_rdata == 8'h43);
endmodule

bind crtc_regport crtc_regport_chk #(.EXT_NUM(EXT_NUM), .EXT_BASE(EXT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_rdata(io_rdata),
  .vblank(vblank), .color(misc_q[0]), .idx_q(idx_q), .ulk_st(ulk_st),
  .mode_q(mode_q), .busy_q(busy_q), .prot(prot), .ext_q(ext_q), .std_lo(std_q[7:0])
);

// File: tb/sim_crtc_regport.sv
`timescale 1ns/1ps
module sim_crtc_regport;
  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0, vblank = 0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [9:0] line_pitch;
  int total = 0, fails = 0;
  logic [15:0] ipb = 16'h03B4;
  bit done = 0;

  always #2.5 clk = ~clk;

  crtc_regport u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .vblank(vblank), .line_pitch(line_pitch));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    #1 d = io_rdata; io_rd = 0;
  endtask

  task automatic wreg(logic [7:0] i, logic [7:0] d);
    wr(ipb, i); wr(ipb + 16'd1, d);
  endtask

  task automatic rreg(logic [7:0] i, output logic [7:0] d);
    wr(ipb, i); rd(ipb + 16'd1, d);
  endtask

  task automatic unlock();
    wreg(8'h30, 8'h57); wr(ipb + 16'd1, 8'h4C);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(16'h03CC, d); chk("R11 misc after reset", d, 8'h00);
    chk("R11 pitch after reset", line_pitch, 10'h000);
    rreg(8'h33, d); chk("R11 busy after reset", d, 8'h00);
    rd(16'h03B4, d); chk("R11 index after reset", d, 8'h33);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    wr(16'h03C2, 8'hE3); rd(16'h03CC, d); chk("R1 misc readback", d, 8'hE3);
    wr(16'h03B4, 8'h12);
    rd(16'h03B5, d); chk("R2 inactive pair reads 0", d, 8'h00);
    ipb = 16'h03D4;
    rd(16'h03D4, d); chk("R2 inactive index write ignored", d, 8'h33);
    wreg(8'h12, 8'h5A); rreg(8'h12, d); chk("R2 color pair data", d, 8'h5A);
    rd(16'h03D4, d); chk("R2 index readback", d, 8'h12);
  endtask

  task automatic t_std();
    logic [7:0] d;
    wreg(8'h02, 8'h21); rreg(8'h02, d); chk("R5 std write", d, 8'h21);
    wreg(8'h11, 8'h80);
    wreg(8'h02, 8'h33); rreg(8'h02, d); chk("R5 protected write ignored", d, 8'h21);
    wreg(8'h07, 8'h44); rreg(8'h07, d); chk("R5 top protected index", d, 8'h00);
    wreg(8'h18, 8'h66); rreg(8'h18, d); chk("R5 unprotected index", d, 8'h66);
    wreg(8'h11, 8'h00);
    wreg(8'h02, 8'h33); rreg(8'h02, d); chk("R5 protection lifted", d, 8'h33);
  endtask

  task automatic t_key();
    logic [7:0] d;
    wreg(8'h42, 8'h99); unlock(); rreg(8'h42, d); chk("R4 locked write ignored", d, 8'h00);
    wreg(8'h42, 8'h99); rreg(8'h42, d); chk("R4 open write", d, 8'h99);
    wreg(8'h30, 8'h00); rreg(8'h42, d); chk("R4 locked read 0", d, 8'h00);
    rreg(8'h30, d); chk("R3 key index reads 0", d, 8'h00);
    wreg(8'h30, 8'h57); wr(ipb + 16'd1, 8'h12); wr(ipb + 16'd1, 8'h4C);
    rreg(8'h42, d); chk("R3 broken order stays locked", d, 8'h00);
    wreg(8'h30, 8'h4C); rreg(8'h42, d); chk("R3 lone second byte", d, 8'h00);
    unlock(); rreg(8'h42, d); chk("R4 contents kept across lock", d, 8'h99);
    wreg(8'h4F, 8'h7E); rreg(8'h4F, d); chk("R4 last ext index", d, 8'h7E);
  endtask

  task automatic t_pitch();
    wreg(8'h13, 8'h80); wreg(8'h45, 8'hFF);
    #1 chk("R6 pitch assembly", line_pitch, 10'h380);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    wreg(8'h30, 8'h00);
    wreg(8'h3F, 8'h01); rreg(8'h3F, d); chk("R7 locked mode write ignored", d, 8'h00);
    unlock();
    wreg(8'h3F, 8'hFF); rreg(8'h3F, d); chk("R7 mode bit readback", d, 8'h01);
    rreg(8'h33, d); chk("R8 not busy while active", d, 8'h00);
    wreg(8'h3F, 8'h00); rreg(8'h33, d); chk("R8 busy after clear", d, 8'h80);
    repeat (5) @(negedge clk);
    rreg(8'h33, d); chk("R8 busy holds", d, 8'h80);
    @(negedge clk); vblank = 1; @(negedge clk); vblank = 0;
    rreg(8'h33, d); chk("R8 busy cleared by vblank", d, 8'h00);
    wreg(8'h3F, 8'h01); wr(ipb, 8'h3F);
    @(negedge clk); io_addr = ipb + 16'd1; io_wdata = 8'h00; io_wr = 1; vblank = 1;
    @(negedge clk); io_wr = 0; vblank = 0;
    rreg(8'h33, d); chk("R8 set wins over vblank", d, 8'h80);
    @(negedge clk); vblank = 1; @(negedge clk); vblank = 0;
  endtask

  task automatic t_sig_unimpl();
    logic [7:0] d;
    wreg(8'h30, 8'h00);
    rreg(8'h35, d); chk("R9 signature C", d, 8'h43);
    rreg(8'h36, d); chk("R9 signature X", d, 8'h58);
    wreg(8'h20, 8'h55); rreg(8'h20, d); chk("R10 unimplemented index", d, 8'h00);
    wreg(8'h36, 8'h00); rreg(8'h36, d); chk("R10 signature not writable", d, 8'h58);
  endtask

  task automatic t_rst_again();
    logic [7:0] d;
    @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    ipb = 16'h03B4;
    rd(16'h03CC, d); chk("R11 misc cleared", d, 8'h00);
    chk("R11 pitch cleared", line_pitch, 10'h000);
    unlock(); rreg(8'h42, d); chk("R11 ext cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset(); t_ports(); t_std(); t_key(); t_pitch(); t_mode(); t_sig_unimpl(); t_rst_again();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule